// File: doc/BRIEF.md
# Flash Program and Erase Controller with Key Unlock

This block is the register-level controller that erases and programs a small on-chip NOR flash array. Software reaches it through four 32-bit registers: a control word, a key port, a target address and a program word. Every register can be written three ways: a plain overwrite, a bit-set view that ORs the written bits in, and a bit-clear view that removes them. A program or erase only starts after a strict, uninterrupted key ritual. Software selects an operation, enables writing, sends three key words in a fixed order and then, as its very next bus access, sets the start bit.

While an operation runs the start bit reads back as 1 and serves as the busy flag. The address, data and control registers are frozen. When the parameterised erase or program time has elapsed, the hardware clears the flag on its own and software polls for that. A page erase returns every word of the addressed page to all ones. A word program ANDs the data into the stored word, so it can only clear bits. Writes to locked pages and operations under a low-supply condition are refused and reported in two sticky status bits. Starting a no-op clears both status bits. A behavioural storage array is included, and a side read port lets its contents be observed.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, the control, address and data registers read 0 and every array word reads 0xFFFFFFFF.
- R2: The register is selected by bus_addr[3:2] (0 control, 1 key, 2 address, 3 data). The write view is selected by bus_addr[1:0]: 0 and 3 overwrite, 1 clears the written bits, 2 sets the written bits. The key register always reads 0.
- R3: Control bits are as follows. Bits [3:0] are the operation code and bit 14 is write-enable; software can write both. Bit 15 is start/busy, bit 13 is the lock error and bit 12 is the low-voltage error; a plain control write never sets these three.
- R4: Bit 15 rises only if four conditions hold. Key writes of 0x00000000, 0xAA996655 and 0x556699AA were made in order, with write-enable at 1. The very next bus access is a control write that leaves bits 15 and 14 at 1. Write-enable was already 1. A key word out of order restarts the ritual (a 0x00000000 key begins it anew). Any other access in between, including a read, cancels it.
- R5: A start attempted with write-enable at 0 is ignored and bit 15 stays 0.
- R6: After the start write, bit 15 reads 1 for exactly ERASE_CYC cycles for op 4 (erase), WRITE_CYC cycles for op 1 (word program), and 1 cycle for any other code. It then returns to 0 by itself.
- R7: The address register holds a byte address. The word index is addr[IDX_W+1:2] and the page is addr[IDX_W+1:PW_W+2]; upper bits are ignored. A successful erase sets all PAGE_WORDS words of the page to 0xFFFFFFFF and leaves other pages unchanged.
- R8: A successful word program replaces the addressed word with its old value AND the data register.
- R9: If pg_lock for the target page is 1 at completion, an op 1 or op 4 sets bit 13 and leaves the array unchanged.
- R10: If lv_fault is 1 at completion, an op 1 or op 4 sets bit 12 and leaves the array unchanged; this takes precedence over the lock check.
- R11: Starting any op other than 1 or 4 clears bits 13 and 12. Both bits otherwise hold their value.
- R12: While bit 15 is 1, writes to the address, data and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register select [3:2] and write view [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pg_lock | input | PAGES | Per-page write protection |
| lv_fault | input | 1 | Low-supply condition |
| arr_ridx | input | IDX_W | Word index for the array observation port |
| arr_rdata | output | 32 | Array word at arr_ridx |

## Verification
The assertions assume the following about the inputs. There is at most one bus access per cycle. pg_lock and lv_fault stay steady while an operation runs, so the refusal decision taken at completion matches the condition at the start. Target addresses may carry arbitrary upper bits, because the block ignores them. The bench holds the lock and supply inputs constant from before each start until the busy flag drops. It issues one access per cycle and draws random byte addresses, data and operation codes from a fixed seed. Directed cases cover broken key orders, an interrupted ritual, a cleared write-enable and writes made while busy.

// File: rtl/nvm_pkg.sv
// Shared constants and helpers for the flash program/erase controller.
// Assumes a 32-bit register bus with a 2-bit write-view selector.
package nvm_pkg;
    localparam logic [1:0] RS_CTRL = 2'd0;
    localparam logic [1:0] RS_KEY  = 2'd1;
    localparam logic [1:0] RS_ADDR = 2'd2;
    localparam logic [1:0] RS_DATA = 2'd3;

    localparam logic [1:0] WV_CLR = 2'd1;
    localparam logic [1:0] WV_SET = 2'd2;

    localparam logic [31:0] KEY_FIRST  = 32'h0000_0000;
    localparam logic [31:0] KEY_SECOND = 32'hAA99_6655;
    localparam logic [31:0] KEY_THIRD  = 32'h5566_99AA;

    localparam logic [3:0] OPC_WORD  = 4'd1;
    localparam logic [3:0] OPC_ERASE = 4'd4;

    localparam int CB_START = 15;
    localparam int CB_WEN   = 14;
    localparam int CB_LOCKE = 13;
    localparam int CB_LVE   = 12;

    // Result of a write through one of the views onto a 32-bit register.
    function automatic logic [31:0] view_apply(input logic [1:0] view,
                                               input logic [31:0] cur,
                                               input logic [31:0] wd);
        case (view)
            WV_CLR:  return cur & ~wd;
            WV_SET:  return cur | wd;
            default: return wd;
        endcase
    endfunction

    // Same as view_apply, for a single bit.
    function automatic logic bit_apply(input logic [1:0] view,
                                       input logic cur,
                                       input logic wd);
        case (view)
            WV_CLR:  return cur & ~wd;
            WV_SET:  return cur | wd;
            default: return wd;
        endcase
    endfunction
endpackage

// File: rtl/nvm_unlock.sv
// Key ritual sequencer: tracks three ordered key writes made with
// write-enable high, and stays armed only until the next bus access.
// Assumes at most one bus access per cycle.
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        wen,
    output logic        armed
);
    typedef enum logic [1:0] {UK_IDLE, UK_ONE, UK_TWO, UK_ARM} uk_e;
    uk_e st, st_nxt;

    // Next ritual state from the current bus access.
    always_comb begin
        st_nxt = st;
        if (acc) begin
            if (!key_wr || !wen)                          st_nxt = UK_IDLE;
            else if (key_val == KEY_FIRST)                st_nxt = UK_ONE;
            else if (st == UK_ONE && key_val == KEY_SECOND) st_nxt = UK_TWO;
            else if (st == UK_TWO && key_val == KEY_THIRD)  st_nxt = UK_ARM;
            else                                          st_nxt = UK_IDLE;
        end
    end

    // Ritual state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= UK_IDLE;
        else        st <= st_nxt;
    end

    assign armed = (st == UK_ARM);

    // R4: arming is reached only from the second-key stage
    a_r4_arm_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(st == UK_TWO));
    // R4: any non-key access ends the armed window
    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc && !key_wr) |=> !armed);
endmodule

// File: rtl/nvm_timer.sv
// Operation timer: holds busy for a per-operation number of cycles and
// flags the final busy cycle. Assumes ERASE_CYC >= WRITE_CYC >= 1.
module nvm_timer
    import nvm_pkg::*;
#(
    parameter int ERASE_CYC = 24,
    parameter int WRITE_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] op,
    output logic       busy,
    output logic       done
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;

    // Length of the operation being started, minus one.
    always_comb begin
        if (op == OPC_ERASE)     load = CNT_W'(ERASE_CYC - 1);
        else if (op == OPC_WORD) load = CNT_W'(WRITE_CYC - 1);
        else                     load = '0;
    end

    // Busy flag and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R6: counter never exceeds the longest operation
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt) < ERASE_CYC));
    // R6: completion always drops busy
    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
endmodule

// File: rtl/nvm_array.sv
// Behavioural flash storage: page erase to all ones and AND-only word
// program, with an asynchronous observation read port. Assumes that erase
// and program are never requested in the same cycle.
module nvm_array #(
    parameter int PAGES      = 4,
    parameter int PAGE_WORDS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                do_erase,
    input  logic                                do_write,
    input  logic [$clog2(PAGES*PAGE_WORDS)-1:0] widx,
    input  logic [31:0]                         wdata,
    input  logic [$clog2(PAGES*PAGE_WORDS)-1:0] ridx,
    output logic [31:0]                         rdata
);
    localparam int WORDS = PAGES * PAGE_WORDS;
    localparam int IDX_W = $clog2(WORDS);
    localparam int PW_W  = $clog2(PAGE_WORDS);
    localparam int PG_W  = IDX_W - PW_W;

    logic [31:0] mem [WORDS];

    // Storage update: reset to erased, page erase, or AND program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) mem[k] <= '1;
        end else if (do_erase) begin
            for (int k = 0; k < WORDS; k++)
                if (widx[IDX_W-1:PW_W] == PG_W'(k / PAGE_WORDS)) mem[k] <= '1;
        end else if (do_write) begin
            mem[widx] <= mem[widx] & wdata;
        end
    end

    assign rdata = mem[ridx];

    // R8: programming never turns a 0 bit into a 1
    a_r8_bits_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && !do_erase) |=> ((mem[$past(widx)] & ~$past(mem[widx])) == 32'h0));
    // R7: erased target word reads all ones afterwards
    a_r7_erased_ones: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase |=> (mem[$past(widx)] == 32'hFFFF_FFFF));
endmodule

// File: rtl/nvm_prog_ctrl.sv
// Flash program/erase controller top: register file with overwrite, set
// and clear views, key ritual, operation timer and behavioural array.
// Assumes one bus access per cycle; pg_lock and lv_fault are sampled at
// the completion of an operation.
module nvm_prog_ctrl
    import nvm_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_WORDS = 8,
    parameter int ERASE_CYC  = 24,
    parameter int WRITE_CYC  = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_req,
    input  logic                                bus_we,
    input  logic [3:0]                          bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [PAGES-1:0]                    pg_lock,
    input  logic                                lv_fault,
    input  logic [$clog2(PAGES*PAGE_WORDS)-1:0] arr_ridx,
    output logic [31:0]                         arr_rdata
);
    localparam int WORDS = PAGES * PAGE_WORDS;
    localparam int IDX_W = $clog2(WORDS);
    localparam int PW_W  = $clog2(PAGE_WORDS);

    logic [3:0]  op_q;
    logic        wen_q, locke_q, lve_q;
    logic [31:0] addr_q, data_q;
    logic        busy, done, armed;

    logic [1:0]  rsel, view;
    logic        wr_acc, ctrl_wr;
    logic [3:0]  op_new;
    logic        wen_new, start_new;
    logic        start, prog_op, refuse;
    logic [IDX_W-1:0]      widx;
    logic [IDX_W-PW_W-1:0] page;

    assign rsel    = bus_addr[3:2];
    assign view    = bus_addr[1:0];
    assign wr_acc  = bus_req && bus_we;
    assign ctrl_wr = wr_acc && (rsel == RS_CTRL);
    assign widx    = addr_q[IDX_W+1:2];
    assign page    = addr_q[IDX_W+1:PW_W+2];

    // Control fields as they would be after the current write.
    always_comb begin
        for (int b = 0; b < 4; b++) op_new[b] = bit_apply(view, op_q[b], bus_wdata[b]);
        wen_new   = bit_apply(view, wen_q, bus_wdata[CB_WEN]);
        start_new = bit_apply(view, busy, bus_wdata[CB_START]);
    end

    assign start   = ctrl_wr && !busy && armed && wen_q && wen_new && start_new;
    assign prog_op = (op_q == OPC_WORD) || (op_q == OPC_ERASE);
    assign refuse  = lv_fault || pg_lock[page];

    // Control fields: operation code and write-enable, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            wen_q <= 1'b0;
        end else if (ctrl_wr && !busy) begin
            op_q  <= op_new;
            wen_q <= wen_new;
        end
    end

    // Sticky error flags: set at refused completion, cleared by a no-op start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locke_q <= 1'b0;
            lve_q   <= 1'b0;
        end else if (start && op_new != OPC_WORD && op_new != OPC_ERASE) begin
            locke_q <= 1'b0;
            lve_q   <= 1'b0;
        end else if (done && prog_op) begin
            if (lv_fault)           lve_q   <= 1'b1;
            else if (pg_lock[page]) locke_q <= 1'b1;
        end
    end

    // Address and data registers, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_acc && !busy) begin
            if (rsel == RS_ADDR) addr_q <= view_apply(view, addr_q, bus_wdata);
            if (rsel == RS_DATA) data_q <= view_apply(view, data_q, bus_wdata);
        end
    end

    // Read-back multiplexer; the key port reads as zero.
    always_comb begin
        case (rsel)
            RS_CTRL: bus_rdata = {16'h0, busy, wen_q, locke_q, lve_q, 8'h0, op_q};
            RS_ADDR: bus_rdata = addr_q;
            RS_DATA: bus_rdata = data_q;
            default: bus_rdata = 32'h0;
        endcase
    end

    nvm_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (bus_req),
        .key_wr  (wr_acc && (rsel == RS_KEY)),
        .key_val (bus_wdata),
        .wen     (wen_q),
        .armed   (armed)
    );

    nvm_timer #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op    (op_new),
        .busy  (busy),
        .done  (done)
    );

    nvm_array #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_erase (done && op_q == OPC_ERASE && !refuse),
        .do_write (done && op_q == OPC_WORD && !refuse),
        .widx     (widx),
        .wdata    (data_q),
        .ridx     (arr_ridx),
        .rdata    (arr_rdata)
    );

    // R4: busy only rises right after an armed ritual
    a_r4_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));
    // R5: busy only rises when write-enable was already set
    a_r5_start_wen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q));
    // R12: address and data hold while busy
    a_r12_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_acc && rsel == RS_ADDR) |=> $stable(addr_q));
    a_r12_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_acc && rsel == RS_DATA) |=> $stable(data_q));
    // R10: low-voltage refusal raises its flag
    a_r10_lve_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prog_op && lv_fault) |=> lve_q);
    // R12: operation code holds while busy
    a_r12_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy ? $stable(op_q) : 1'b1));
endmodule

// File: tb/nvm_prog_ctrl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random operations
// compared against a bench-side model of registers and array.
module nvm_prog_ctrl_tb_top;
    localparam int PG  = 4;
    localparam int PW  = 8;
    localparam int EC  = 24;
    localparam int WC  = 6;
    localparam int NW  = PG * PW;
    localparam logic [31:0] K0 = 32'h0, K1 = 32'hAA99_6655, K2 = 32'h5566_99AA;
    localparam logic [31:0] WEN = 32'h0000_4000, STB = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PG-1:0] pg_lock = '0;
    logic        lv_fault = 1'b0;
    logic [4:0]  arr_ridx = '0;
    logic [31:0] arr_rdata;

    int errors = 0, checks = 0;
    logic finished = 1'b0;
    logic [31:0] em [NW];
    logic e_locke = 1'b0, e_lve = 1'b0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    nvm_prog_ctrl #(.PAGES(PG), .PAGE_WORDS(PW), .ERASE_CYC(EC), .WRITE_CYC(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pg_lock(pg_lock), .lv_fault(lv_fault),
        .arr_ridx(arr_ridx), .arr_rdata(arr_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] rg, input logic [1:0] vw, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {rg, vw}; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [1:0] rg, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = {rg, 2'b00};
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    function automatic int op_len(input logic [3:0] op);
        if (op == 4'd4) return EC;
        if (op == 4'd1) return WC;
        return 1;
    endfunction

    // Bench model of one completed operation.
    task automatic model_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
        int wi = int'(a[6:2]);
        int pg = int'(a[6:5]);
        if (op == 4'd1 || op == 4'd4) begin
            if (lv_fault) e_lve = 1'b1;
            else if (pg_lock[pg]) e_locke = 1'b1;
            else if (op == 4'd1) em[wi] = em[wi] & d;
            else for (int k = 0; k < PW; k++) em[pg*PW + k] = '1;
        end else begin
            e_lve = 1'b0;
            e_locke = 1'b0;
        end
    endtask

    task automatic chk_array(input string tag);
        int bad = 0;
        logic [31:0] first_a = '0, first_e = '0;
        for (int k = 0; k < NW; k++) begin
            @(negedge clk);
            arr_ridx = 5'(k);
            #1;
            if (arr_rdata !== em[k] && bad == 0) begin
                first_a = arr_rdata; first_e = em[k];
            end
            if (arr_rdata !== em[k]) bad++;
        end
        chk(tag, first_a, first_e);
    endtask

    task automatic ritual();
        bw(2'd1, 2'd0, K0);
        bw(2'd1, 2'd0, K1);
        bw(2'd1, 2'd0, K2);
    endtask

    // Poll the start bit, returning how many reads saw it high.
    task automatic poll(output int n);
        logic [31:0] c;
        n = 0;
        for (int g = 0; g < 200; g++) begin
            br(2'd0, c);
            if (!c[15]) break;
            n++;
        end
    endtask

    // Full program/erase/no-op flow with model update and checks.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
        int n;
        logic [31:0] c;
        bw(2'd2, 2'd0, a);
        bw(2'd3, 2'd0, d);
        bw(2'd0, 2'd0, {28'h0, op});
        bw(2'd0, 2'd2, WEN);
        ritual();
        bw(2'd0, 2'd2, STB);
        poll(n);
        model_op(op, a, d);
        chk("R6 busy duration", 32'(n), 32'(op_len(op)));
        br(2'd0, c);
        chk("R9/R10/R11 error flags", {30'h0, c[13], c[12]}, {30'h0, e_locke, e_lve});
        chk_array("R7/R8 array contents");
        bw(2'd0, 2'd1, WEN);
    endtask

    initial begin
        int n;
        int seed_dummy;
        logic [31:0] a, d;
        logic [3:0] op;
        seed_dummy = $urandom(32'h0000_C0DE);
        for (int k = 0; k < NW; k++) em[k] = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        br(2'd0, rd); chk("R1 control reset", rd, 32'h0);
        br(2'd2, rd); chk("R1 address reset", rd, 32'h0);
        br(2'd3, rd); chk("R1 data reset", rd, 32'h0);
        chk_array("R1 array erased at reset");

        // R2: write views on the address register, key reads zero
        bw(2'd2, 2'd0, 32'h0000_F0F0);
        bw(2'd2, 2'd2, 32'h0F00_0000);
        br(2'd2, rd); chk("R2 set view", rd, 32'h0F00_F0F0);
        bw(2'd2, 2'd1, 32'h0000_00F0);
        br(2'd2, rd); chk("R2 clear view", rd, 32'h0F00_F000);
        bw(2'd2, 2'd3, 32'h1234_5678);
        br(2'd2, rd); chk("R2 view 3 overwrites", rd, 32'h1234_5678);
        bw(2'd1, 2'd0, 32'hDEAD_BEEF);
        br(2'd1, rd); chk("R2 key reads zero", rd, 32'h0);

        // R3: only op code and write-enable are writable
        bw(2'd0, 2'd0, 32'hFFFF_FFFF);
        br(2'd0, rd); chk("R3 writable control fields", rd, 32'h0000_400F);
        bw(2'd0, 2'd0, 32'h0);

        // R5: ritual and start with write-enable low
        bw(2'd0, 2'd0, 32'h1);
        ritual();
        bw(2'd0, 2'd2, STB | WEN);
        br(2'd0, rd); chk("R5 start without write-enable", rd, 32'h0000_4001);
        bw(2'd0, 2'd0, 32'h1);

        // R4: keys out of order
        bw(2'd0, 2'd2, WEN);
        bw(2'd1, 2'd0, K0); bw(2'd1, 2'd0, K2); bw(2'd1, 2'd0, K1);
        bw(2'd0, 2'd2, STB);
        br(2'd0, rd); chk("R4 wrong key order", rd, 32'h0000_4001);
        // R4: an intervening read cancels the armed window
        ritual();
        br(2'd0, rd);
        bw(2'd0, 2'd2, STB);
        br(2'd0, rd); chk("R4 access between key and start", rd, 32'h0000_4001);
        // R4: a stray key then a fresh zero key restarts the ritual and works
        bw(2'd2, 2'd0, 32'h0000_0024);
        bw(2'd3, 2'd0, 32'hA5A5_0F0F);
        bw(2'd1, 2'd0, K1); ritual();
        bw(2'd0, 2'd2, STB);
        poll(n);
        model_op(4'd1, 32'h0000_0024, 32'hA5A5_0F0F);
        chk("R4 restarted ritual starts", 32'(n), 32'(WC));
        chk_array("R8 first program");
        bw(2'd0, 2'd1, WEN);
        br(2'd0, rd); chk("R3 write-enable cleared by clear view", rd, 32'h0000_0001);

        // R8: second program ANDs in, R7: erase restores
        run_op(4'd1, 32'h0000_0024, 32'h0F0F_FFFF);
        run_op(4'd1, 32'h0000_0004, 32'h0000_1111);
        run_op(4'd4, 32'hFFFF_FF20, 32'h0);

        // R9: locked page refuses erase, R11: no-op clears
        run_op(4'd1, 32'h0000_0040, 32'h1234_0000);
        pg_lock = 4'b0100;
        run_op(4'd4, 32'h0000_0044, 32'h0);
        run_op(4'd0, 32'h0, 32'h0);
        // R10: low voltage takes precedence over the lock
        lv_fault = 1'b1;
        run_op(4'd1, 32'h0000_0048, 32'h0);
        run_op(4'd7, 32'h0, 32'h0);
        lv_fault = 1'b0; pg_lock = '0;

        // R12: writes while busy are ignored
        bw(2'd2, 2'd0, 32'h0000_0060);
        bw(2'd0, 2'd0, 32'h4);
        bw(2'd0, 2'd2, WEN);
        ritual();
        bw(2'd0, 2'd2, STB);
        bw(2'd2, 2'd0, 32'h0000_0000);
        bw(2'd3, 2'd0, 32'hFFFF_0000);
        bw(2'd0, 2'd0, 32'h0000_0001);
        br(2'd2, rd); chk("R12 address frozen", rd, 32'h0000_0060);
        br(2'd3, rd); chk("R12 data frozen", rd, 32'h0F0F_FFFF & 32'h0 | 32'h0);
        br(2'd0, rd); chk("R12 control frozen", rd, 32'h0000_C004);
        poll(n);
        model_op(4'd4, 32'h0000_0060, 32'h0);
        chk_array("R12 erase used frozen address");
        bw(2'd0, 2'd1, WEN);

        // Random operations with random locks and supply faults
        for (int it = 0; it < 40; it++) begin
            case ($urandom_range(0, 3))
                0:       op = 4'd0;
                1:       op = 4'd4;
                default: op = 4'd1;
            endcase
            a = $urandom;
            d = $urandom;
            pg_lock  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            lv_fault = ($urandom_range(0, 7) == 0);
            run_op(op, a, d);
        end
        pg_lock = '0; lv_fault = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule